// File: doc/BRIEF.md
# Dual-ALU Steering and Hazard Control

This unit controls operand delivery in a five-stage in-order pipeline with two arithmetic units. The first (ALU1) sits in stage 3 (EX1). The second (ALU2) sits in stage 4 (EX2/MEM), beside the data memory. As each instruction leaves decode, the unit chooses which arithmetic unit it will run on and records that choice in a shadow copy of the pipeline registers. From that shadow state it drives the bypass multiplexer selects for the EX1 operands and for the stage-4 operands. It also selects the stage-4 result source. It raises a one-cycle stall when a memory address base cannot reach ALU1 in time. Branches and jumps are not handled.

Loads and stores always form their address on ALU1. An ALU instruction goes to ALU1 when every source it reads can be supplied to stage 3 in the next cycle. Otherwise it is deferred to ALU2, which sees its operands one cycle later. The register file is assumed to write before it reads, so a producer in writeback is already visible to decode.

Flow is tracked by a small state machine with three states. IDLE holds while nothing is in flight. RUN is normal issue. HOLD is the single cycle in which a stalled instruction is presented again. The transitions are: IDLE to RUN on any valid decode or occupied stage; RUN to HOLD when a stall is raised; HOLD to RUN unconditionally; RUN to IDLE when decode and all shadow stages are empty.

Top module: `dual_alu_hazard_ctrl`

## Requirements
- R1: After reset, with no valid decode, every output is 0.
- R2: A decoded load (class 2) or store (class 3) always drives `id_use_alu2` to 0.
- R3: A decoded ALU instruction (class 1) drives `id_use_alu2` to 1 exactly when a used, nonzero source is written by the instruction now in EX1, and that instruction is a load or a deferred ALU instruction. Otherwise `id_use_alu2` is 0. Classes 0, 2 and 3 and invalid slots drive 0.
- R4: `stall` is 1 exactly when a decoded load or store has its base (rs) written by an EX1 load or deferred ALU instruction. No two consecutive cycles stall.
- R5: `bubble` equals `stall`. In the cycle after a stall, EX1 holds no instruction: `ex1_alu1_en` is 0 and both EX1 selects are 0.
- R6: Each EX1 operand select uses this encoding: 1 takes the stage-4 ALU1 result, 2 takes the writeback value, 0 keeps the decoded register value. The newest producer wins. A stage-4 producer that is a load or a deferred ALU instruction yields 0.
- R7: `mem_fwd_a` and `mem_fwd_b` are 1 when the stage-4 instruction needs that source now and the writeback instruction writes it. Source a is needed by a deferred ALU instruction. Source b is needed by a deferred ALU instruction and by a store's data.
- R8: `mem_res_sel` is 2 for a load in stage 4, 1 for a deferred ALU instruction, and 0 otherwise.
- R9: `ex1_alu1_en` is 1 for a load, a store or a non-deferred ALU instruction in EX1. `mem_alu2_en` is 1 only for a deferred ALU instruction in stage 4.
- R10: Register 0 never creates a dependency for steering, stalling or forwarding.
- R11: An ALU instruction that issues from decode with `id_use_alu2` set has `mem_alu2_en` set two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_class | input | 2 | 0 nop, 1 ALU, 2 load, 3 store |
| id_rs | input | 5 | First source (address base for memory ops) |
| id_rt | input | 5 | Second source (store data) |
| id_dst | input | 5 | Destination for ALU and load |
| id_rs_used | input | 1 | First source is read |
| id_rt_used | input | 1 | Second source is read |
| id_use_alu2 | output | 1 | Decode instruction is deferred to ALU2 |
| stall | output | 1 | Hold PC and decode register |
| bubble | output | 1 | Insert a nop into EX1 |
| ex1_fwd_a | output | 2 | EX1 first operand select |
| ex1_fwd_b | output | 2 | EX1 second operand select |
| ex1_alu1_en | output | 1 | ALU1 active in stage 3 |
| mem_fwd_a | output | 1 | Stage-4 first operand takes writeback value |
| mem_fwd_b | output | 1 | Stage-4 second operand takes writeback value |
| mem_alu2_en | output | 1 | ALU2 active in stage 4 |
| mem_res_sel | output | 2 | Stage-4 result source |

## Verification
The assertions take for granted that decode flags its sources consistently: loads and stores set `id_rs_used`, stores set `id_rt_used`, loads clear it. They also assume the same instruction is presented again in the cycle after a stall. The stimulus derives the use flags from the class it draws, and it repeats an instruction whenever its own model predicts a stall. Registers are drawn from a narrow range, with register 0 included, so dependencies and zero-register cases occur often.

// File: rtl/dual_alu_pkg.sv
package dual_alu_pkg;
    localparam int REG_AW = 5;
    localparam int NSRC   = 2;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        CLS_NOP   = 2'd0,
        CLS_ALU   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_STORE = 2'd3
    } iclass_t;

    typedef enum logic [SEL_W-1:0] {
        FWD_REG = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } ex1_fwd_t;

    typedef enum logic [SEL_W-1:0] {
        RES_ALU1 = 2'd0,
        RES_ALU2 = 2'd1,
        RES_DMEM = 2'd2
    } res_sel_t;

    typedef struct packed {
        logic                         vld;
        iclass_t                      cls;
        logic [NSRC-1:0][REG_AW-1:0]  src;
        logic [NSRC-1:0]              src_use;
        logic [REG_AW-1:0]            dst;
        logic                         on_alu2;
    } slot_t;

    function automatic logic slot_writes(slot_t s, logic [REG_AW-1:0] r);
        return s.vld && (s.cls == CLS_ALU || s.cls == CLS_LOAD) &&
               (r != '0) && (s.dst == r);
    endfunction

    function automatic logic result_early(slot_t s);
        return s.cls == CLS_ALU && !s.on_alu2;
    endfunction

    function automatic logic is_mem(slot_t s);
        return s.cls == CLS_LOAD || s.cls == CLS_STORE;
    endfunction
endpackage

// File: rtl/dual_alu_steer.sv
module dual_alu_steer
    import dual_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t id_slot,
    input  slot_t ex1_slot,
    output logic  use_alu2,
    output logic  need_stall
);
    logic [NSRC-1:0] late;

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_late
            assign late[k] = id_slot.src_use[k] &&
                             slot_writes(ex1_slot, id_slot.src[k]) &&
                             !result_early(ex1_slot);
        end
    endgenerate

    always_comb begin
        use_alu2   = 1'b0;
        need_stall = 1'b0;
        if (id_slot.vld) begin
            unique case (id_slot.cls)
                CLS_ALU:             use_alu2   = |late;
                CLS_LOAD, CLS_STORE: need_stall = late[0];
                default:             ;
            endcase
        end
    end

    // R2: address arithmetic never leaves ALU1
    p_mem_on_alu1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_slot.vld && is_mem(id_slot)) |-> !use_alu2)
        else $error("memory op steered to ALU2");
endmodule

// File: rtl/dual_alu_shadow.sv
module dual_alu_shadow
    import dual_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t id_slot,
    input  logic  id_alu2,
    input  logic  insert_bubble,
    output slot_t ex1_slot,
    output slot_t mem_slot,
    output slot_t wb_slot,
    output logic  busy
);
    slot_t enter;

    always_comb begin
        enter         = id_slot;
        enter.on_alu2 = id_alu2;
        if (insert_bubble || !id_slot.vld)
            enter = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex1_slot <= '0;
            mem_slot <= '0;
            wb_slot  <= '0;
        end else begin
            ex1_slot <= enter;
            mem_slot <= ex1_slot;
            wb_slot  <= mem_slot;
        end
    end

    assign busy = ex1_slot.vld | mem_slot.vld | wb_slot.vld;
endmodule

// File: rtl/dual_alu_fwd.sv
module dual_alu_fwd
    import dual_alu_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  slot_t                       ex1_slot,
    input  slot_t                       mem_slot,
    input  slot_t                       wb_slot,
    output logic [NSRC-1:0][SEL_W-1:0]  ex1_fwd,
    output logic [NSRC-1:0]             mem_fwd,
    output logic                        ex1_alu1_en,
    output logic                        mem_alu2_en,
    output logic [SEL_W-1:0]            res_sel
);
    logic ex1_alu1_instr;
    logic mem_deferred;

    assign ex1_alu1_instr = ex1_slot.vld && result_early(ex1_slot);
    assign mem_deferred   = mem_slot.vld && mem_slot.cls == CLS_ALU && mem_slot.on_alu2;

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_src
            logic [SEL_W-1:0] fsel;
            logic             need_now;
            logic             alu1_reader;

            always_comb begin
                fsel = FWD_REG;
                if (ex1_slot.vld && ex1_slot.src_use[k]) begin
                    if (slot_writes(mem_slot, ex1_slot.src[k]))
                        fsel = result_early(mem_slot) ? FWD_MEM : FWD_REG;
                    else if (slot_writes(wb_slot, ex1_slot.src[k]))
                        fsel = FWD_WB;
                end
            end
            assign ex1_fwd[k] = fsel;

            if (k == 0) begin : g_base
                assign need_now    = mem_deferred;
                assign alu1_reader = ex1_alu1_instr ||
                                     (ex1_slot.vld && is_mem(ex1_slot));
            end else begin : g_data
                assign need_now    = mem_deferred ||
                                     (mem_slot.vld && mem_slot.cls == CLS_STORE);
                assign alu1_reader = ex1_alu1_instr;
            end

            assign mem_fwd[k] = need_now && mem_slot.src_use[k] &&
                                slot_writes(wb_slot, mem_slot.src[k]);

            // R6: ALU1 must never read a result that stage 4 has not produced yet
            p_alu1_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(alu1_reader && ex1_slot.src_use[k] &&
                  slot_writes(mem_slot, ex1_slot.src[k]) && !result_early(mem_slot)))
                else $error("ALU1 operand not available");
        end
    endgenerate

    always_comb begin
        res_sel = RES_ALU1;
        if (mem_slot.vld && mem_slot.cls == CLS_LOAD)
            res_sel = RES_DMEM;
        else if (mem_deferred)
            res_sel = RES_ALU2;
    end

    assign ex1_alu1_en = ex1_alu1_instr || (ex1_slot.vld && is_mem(ex1_slot));
    assign mem_alu2_en = mem_deferred;
endmodule

// File: rtl/dual_alu_flow_fsm.sv
module dual_alu_flow_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic need_stall,
    input  logic activity,
    output logic stall
);
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } flow_t;

    flow_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (activity) state_nxt = ST_RUN;
            ST_RUN: begin
                if (need_stall)     state_nxt = ST_HOLD;
                else if (!activity) state_nxt = ST_IDLE;
            end
            ST_HOLD: state_nxt = ST_RUN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_HOLD: stall = 1'b0;
            default: stall = need_stall;
        endcase
    end

    // R4: a stall never lasts more than one cycle
    p_single_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall)
        else $error("stall repeated");
endmodule

// File: rtl/dual_alu_hazard_ctrl.sv
module dual_alu_hazard_ctrl
    import dual_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [1:0]        id_class,
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] id_dst,
    input  logic              id_rs_used,
    input  logic              id_rt_used,
    output logic              id_use_alu2,
    output logic              stall,
    output logic              bubble,
    output logic [SEL_W-1:0]  ex1_fwd_a,
    output logic [SEL_W-1:0]  ex1_fwd_b,
    output logic              ex1_alu1_en,
    output logic              mem_fwd_a,
    output logic              mem_fwd_b,
    output logic              mem_alu2_en,
    output logic [SEL_W-1:0]  mem_res_sel
);
    slot_t                       id_slot, ex1_slot, mem_slot, wb_slot;
    logic                        need_stall, busy;
    logic [NSRC-1:0][SEL_W-1:0]  ex1_fwd;
    logic [NSRC-1:0]             mem_fwd;

    always_comb begin
        id_slot            = '0;
        id_slot.vld        = id_valid;
        id_slot.cls        = iclass_t'(id_class);
        id_slot.src[0]     = id_rs;
        id_slot.src[1]     = id_rt;
        id_slot.src_use[0] = id_rs_used;
        id_slot.src_use[1] = id_rt_used;
        id_slot.dst        = id_dst;
    end

    dual_alu_steer u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_slot    (id_slot),
        .ex1_slot   (ex1_slot),
        .use_alu2   (id_use_alu2),
        .need_stall (need_stall)
    );

    dual_alu_flow_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .need_stall (need_stall),
        .activity   (id_valid | busy),
        .stall      (stall)
    );

    dual_alu_shadow u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_slot       (id_slot),
        .id_alu2       (id_use_alu2),
        .insert_bubble (stall),
        .ex1_slot      (ex1_slot),
        .mem_slot      (mem_slot),
        .wb_slot       (wb_slot),
        .busy          (busy)
    );

    dual_alu_fwd u_fwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex1_slot    (ex1_slot),
        .mem_slot    (mem_slot),
        .wb_slot     (wb_slot),
        .ex1_fwd     (ex1_fwd),
        .mem_fwd     (mem_fwd),
        .ex1_alu1_en (ex1_alu1_en),
        .mem_alu2_en (mem_alu2_en),
        .res_sel     (mem_res_sel)
    );

    assign bubble    = stall;
    assign ex1_fwd_a = ex1_fwd[0];
    assign ex1_fwd_b = ex1_fwd[1];
    assign mem_fwd_a = mem_fwd[0];
    assign mem_fwd_b = mem_fwd[1];

    // R5: the cycle after a stall carries an empty EX1 slot
    p_bubble_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!ex1_alu1_en && ex1_fwd_a == '0 && ex1_fwd_b == '0))
        else $error("EX1 not empty after stall");

    // R11: a deferral chosen in decode reaches stage 4 two cycles later
    p_flag_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_class == CLS_ALU && id_use_alu2 && !stall) |=> ##1 mem_alu2_en)
        else $error("deferral flag lost");
endmodule

// File: tb/dual_alu_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module dual_alu_hazard_ctrl_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       id_valid, id_rs_used, id_rt_used;
    logic [1:0] id_class;
    logic [4:0] id_rs, id_rt, id_dst;
    logic       id_use_alu2, stall, bubble, ex1_alu1_en;
    logic       mem_fwd_a, mem_fwd_b, mem_alu2_en;
    logic [1:0] ex1_fwd_a, ex1_fwd_b, mem_res_sel;

    dual_alu_hazard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
        .id_rs(id_rs), .id_rt(id_rt), .id_dst(id_dst),
        .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
        .id_use_alu2(id_use_alu2), .stall(stall), .bubble(bubble),
        .ex1_fwd_a(ex1_fwd_a), .ex1_fwd_b(ex1_fwd_b), .ex1_alu1_en(ex1_alu1_en),
        .mem_fwd_a(mem_fwd_a), .mem_fwd_b(mem_fwd_b), .mem_alu2_en(mem_alu2_en),
        .mem_res_sel(mem_res_sel)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] c;
        logic [4:0] rs, rt, dst;
        logic       urs, urt, a2;
    } ins_t;

    ins_t q_ex1, q_mem, q_wb;
    int   n_chk = 0, n_fail = 0;
    logic prev_stall = 1'b0;
    logic done = 1'b0;

    function automatic logic wr(ins_t e, logic [4:0] r);
        return e.v && (e.c == 2'd1 || e.c == 2'd2) && r != 5'd0 && e.dst == r;
    endfunction

    function automatic logic late_src(logic [4:0] r, logic u);
        return u && wr(q_ex1, r) && !(q_ex1.c == 2'd1 && !q_ex1.a2);
    endfunction

    function automatic int exp_f1(logic [4:0] r, logic u);
        if (!(q_ex1.v && u && r != 5'd0)) return 0;
        if (wr(q_mem, r)) return (q_mem.c == 2'd1 && !q_mem.a2) ? 1 : 0;
        if (wr(q_wb, r)) return 2;
        return 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycle(input ins_t ins, output logic stalled);
        logic e_a2, e_st, deferred, e_mfa, e_mfb;
        int   e_res;
        string t3;
        @(negedge clk);
        id_valid = ins.v; id_class = ins.c; id_rs = ins.rs; id_rt = ins.rt;
        id_dst = ins.dst; id_rs_used = ins.urs; id_rt_used = ins.urt;
        #1;
        e_a2 = ins.v && ins.c == 2'd1 && (late_src(ins.rs, ins.urs) || late_src(ins.rt, ins.urt));
        e_st = ins.v && (ins.c == 2'd2 || ins.c == 2'd3) && late_src(ins.rs, ins.urs);
        t3 = (ins.c == 2'd2 || ins.c == 2'd3) ? "R2" : "R3";
        if (ins.c == 2'd1 && ((ins.urs && ins.rs == 5'd0) || (ins.urt && ins.rt == 5'd0)))
            t3 = "R3 R10";
        chk(t3, "id_use_alu2", id_use_alu2, e_a2);
        chk("R4", "stall", stall, e_st);
        chk("R5", "bubble", bubble, stall);
        if (prev_stall) chk("R5", "ex1_alu1_en after stall", ex1_alu1_en, 0);
        chk("R6", "ex1_fwd_a", ex1_fwd_a, exp_f1(q_ex1.rs, q_ex1.urs));
        chk("R6", "ex1_fwd_b", ex1_fwd_b, exp_f1(q_ex1.rt, q_ex1.urt));
        chk("R9", "ex1_alu1_en", ex1_alu1_en,
            q_ex1.v && (q_ex1.c == 2'd2 || q_ex1.c == 2'd3 || (q_ex1.c == 2'd1 && !q_ex1.a2)));
        deferred = q_mem.v && q_mem.c == 2'd1 && q_mem.a2;
        e_mfa = deferred && q_mem.urs && wr(q_wb, q_mem.rs);
        e_mfb = (deferred || (q_mem.v && q_mem.c == 2'd3)) && q_mem.urt && wr(q_wb, q_mem.rt);
        chk("R7", "mem_fwd_a", mem_fwd_a, e_mfa);
        chk("R7", "mem_fwd_b", mem_fwd_b, e_mfb);
        chk("R9 R11", "mem_alu2_en", mem_alu2_en, deferred);
        e_res = (q_mem.v && q_mem.c == 2'd2) ? 2 : (deferred ? 1 : 0);
        chk("R8", "mem_res_sel", mem_res_sel, e_res);
        @(posedge clk);
        q_wb  = q_mem;
        q_mem = q_ex1;
        if (e_st || !ins.v) q_ex1 = '0;
        else begin q_ex1 = ins; q_ex1.a2 = e_a2; end
        prev_stall = e_st;
        stalled = e_st;
    endtask

    task automatic issue(input ins_t ins);
        logic s;
        for (int g = 0; g < 4; g++) begin
            cycle(ins, s);
            if (!s) break;
        end
    endtask

    function automatic ins_t mk(logic [1:0] c, logic [4:0] d, logic [4:0] a, logic [4:0] b);
        ins_t i;
        i.v = 1'b1; i.c = c; i.dst = d; i.rs = a; i.rt = b; i.a2 = 1'b0;
        i.urs = (c != 2'd0);
        i.urt = (c == 2'd1 || c == 2'd3);
        return i;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        ins_t r;
        void'($urandom(32'd4242));
        q_ex1 = '0; q_mem = '0; q_wb = '0;
        rst_n = 1'b0;
        id_valid = 0; id_class = 0; id_rs = 0; id_rt = 0; id_dst = 0;
        id_rs_used = 0; id_rt_used = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1", "reset outputs",
            {id_use_alu2, stall, bubble, ex1_fwd_a, ex1_fwd_b, ex1_alu1_en,
             mem_fwd_a, mem_fwd_b, mem_alu2_en, mem_res_sel}, 0);

        // dependent ALU pair stays on ALU1
        issue(mk(2'd1, 5'd1, 5'd2, 5'd3));
        issue(mk(2'd1, 5'd4, 5'd1, 5'd1));
        // load feeding ALU goes to ALU2
        issue(mk(2'd2, 5'd5, 5'd1, 5'd0));
        issue(mk(2'd1, 5'd6, 5'd5, 5'd2));
        // deferred result used as load base: stall
        issue(mk(2'd2, 5'd8, 5'd6, 5'd0));
        // load feeding load base: stall
        issue(mk(2'd2, 5'd9, 5'd1, 5'd0));
        issue(mk(2'd2, 5'd10, 5'd9, 5'd0));
        // store data from a load: no stall, late forward
        issue(mk(2'd2, 5'd11, 5'd2, 5'd0));
        issue(mk(2'd3, 5'd0, 5'd2, 5'd11));
        // register 0 never a dependency
        issue(mk(2'd2, 5'd0, 5'd1, 5'd0));
        issue(mk(2'd1, 5'd12, 5'd0, 5'd0));
        r = '0;
        repeat (4) issue(r);

        for (int n = 0; n < 4000; n++) begin
            logic [1:0] c;
            c = 2'($urandom % 4);
            r = mk(c, 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4));
            if (c == 2'd1) begin
                r.urs = 1'($urandom % 2);
                r.urt = 1'($urandom % 2);
            end
            r.v = ($urandom % 8) != 0;
            issue(r);
        end
        r = '0;
        repeat (4) issue(r);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule